// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block is one programmable cell of a lookup-table logic fabric. A configuration word, written through a simple parallel port, holds a 16-entry truth-table mask and a set of control bits. The cell evaluates its data inputs through that mask and holds one flip-flop. It offers three operating modes. General logic uses one 4-input table. Arithmetic uses two 3-input tables, one for the result and one for a dedicated carry. Up/down counting feeds the register back into the tables and adds a synchronous load.

Cells are meant to sit side by side. Carry-out feeds the next cell's carry-in, which forms ripple adders and counters. Cascade-out feeds the next cell's cascade-in, which forms wide AND or OR functions. The cell has a local output and a global output, and each one selects either the table result or the register. The register can also capture an input that has nothing to do with the table result. This lets one cell carry two unrelated signals.

Top module: `lut_cell`

## Requirements
- R1: `cfg_wdata` is captured into the configuration on a rising `clk` edge while `cfg_we` is 1, and otherwise held. Active-low `rst_n` clears the configuration and the register to all zeros. The field layout is: bits 15:0 mask, bits 17:16 mode, bit 18 carry select, bit 19 cascade OR, bit 20 register packing, bit 21 local select, bit 22 global select.
- R2: In mode 0 (general logic) the table result is `mask[{din[3], x, din[1], din[0]}]` with x = `din[2]`. Mode 3 behaves exactly like mode 0.
- R3: In general logic with carry select = 1, `cin` takes the place of `din[2]` as x.
- R4: In every mode the combined result is table result AND `casc_in` when cascade OR = 0, and table result OR `casc_in` when it is 1. `casc_out` equals this combined result, without any register delay.
- R5: `loc_out` (local select) and `glb_out` (global select) each carry the combined result when their select bit is 0 and the register when it is 1.
- R6: On a rising `clk` edge with `ce` = 1 the register takes its next value. Outside counter mode, with packing = 0, that value is the combined result. With `ce` = 0 the register holds its value.
- R7: With packing = 1 outside counter mode, the register captures `din[3]` directly, while the table still drives the combined result from the inputs.
- R8: In mode 1 (arithmetic) the result is `mask[{cin, din[1], din[0]}]` from the lower half (bits 7:0). `cout` is the same index into the upper half (bits 15:8). In modes 0 and 3, `cout` is 0.
- R9: In mode 2 (counter) the index is `{cin, din[1], q}`, with `din[1]` giving the direction (1 = up) and `din[3]` acting as count enable. When enabled, the register takes the lower-half entry; otherwise it holds. `cout` is the upper-half entry.
- R10: In counter mode, `din[2]` = 1 loads `din[0]` into the register on the clock edge. Load takes priority over the count enable.
- R11: `aclr` = 1 clears the register and `apre` = 1 sets it, both at once, without a clock edge and regardless of `ce`. When both are asserted, clear wins.
- R12: Chaining `cout` into the next `cin` gives a multi-bit ripple adder or counter. Chaining `casc_out` into the next `casc_in` gives a function wider than one table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of configuration and register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 23 | Configuration word |
| din | input | 4 | Data inputs |
| cin | input | 1 | Carry in from the previous cell |
| casc_in | input | 1 | Cascade in from the previous cell |
| ce | input | 1 | Register clock enable |
| aclr | input | 1 | Asynchronous register clear, active high |
| apre | input | 1 | Asynchronous register preset, active high |
| loc_out | output | 1 | Local output |
| glb_out | output | 1 | Global output |
| cout | output | 1 | Carry out |
| casc_out | output | 1 | Cascade out |

## Verification
On every cycle the assertions check several properties. They check that the cascade forces the output in the expected direction, that the two outputs agree when their selects agree, and that the configuration holds without a write. They also check that the register holds with `ce` low, that clear and preset act as defined with clear winning, and that a packed register or a counter load captures the right input. The bench's scenarios cover the rest. These include the exact truth-table contents under each mode, the carry-select substitution, and multi-bit sums and counter wrap across a four-cell chain. They also include a wide AND built through the cascade links, and asynchronous action between clock edges.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
    localparam int LUT_K  = 4;
    localparam int LUT_W  = 1 << LUT_K;
    localparam int HALF_K = LUT_K - 1;
    localparam int HALF_W = LUT_W / 2;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ARITH  = 2'd1,
        MODE_COUNT  = 2'd2,
        MODE_SPARE  = 2'd3
    } mode_e;

    typedef struct packed {
        logic             glb_sel;
        logic             loc_sel;
        logic             reg_pack;
        logic             casc_or;
        logic             cin_sel;
        mode_e            mode;
        logic [LUT_W-1:0] mask;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic comb;
        logic cout;
        logic reg_d;
    } eval_t;
endpackage

// File: rtl/lut_cell_cfg.sv
module lut_cell_cfg
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output cell_cfg_t        cfg_o
);
    cell_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = cell_cfg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R1
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == cell_cfg_t'($past(cfg_wdata)))); // R1
endmodule

// File: rtl/lut_cell_eval.sv
module lut_cell_eval
    import lut_cell_pkg::*;
(
    input  cell_cfg_t        cfg,
    input  logic [LUT_K-1:0] din,
    input  logic             cin,
    input  logic             casc_in,
    input  logic             q,
    output eval_t            ev
);
    logic [HALF_W-1:0] half [2];
    logic [LUT_K-1:0]  idx4;
    logic [HALF_K-1:0] idx3;
    logic              lut4, lut_lo, lut_hi, raw, cnt_next;
    logic              counting, general;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = cfg.mask[h*HALF_W +: HALF_W];
    end

    always_comb begin
        general  = (cfg.mode == MODE_NORMAL) || (cfg.mode == MODE_SPARE);
        counting = (cfg.mode == MODE_COUNT);

        // general logic: fourth table input picked between din[2] and carry-in
        idx4 = {din[3], (cfg.cin_sel ? cin : din[2]), din[1], din[0]};
        lut4 = cfg.mask[idx4];

        // split tables: counter feeds register back in place of din[0]
        idx3   = counting ? {cin, din[1], q} : {cin, din[1], din[0]};
        lut_lo = half[0][idx3];
        lut_hi = half[1][idx3];

        raw     = general ? lut4 : lut_lo;
        ev.comb = cfg.casc_or ? (raw | casc_in) : (raw & casc_in);
        ev.cout = general ? 1'b0 : lut_hi;

        // load mux ahead of the register, load beats count enable
        if (din[2]) begin
            cnt_next = din[0];
        end else if (din[3]) begin
            cnt_next = lut_lo;
        end else begin
            cnt_next = q;
        end

        if (counting) begin
            ev.reg_d = cnt_next;
        end else if (cfg.reg_pack) begin
            ev.reg_d = din[3];
        end else begin
            ev.reg_d = ev.comb;
        end
    end
endmodule

// File: rtl/lut_cell_reg.sv
module lut_cell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic aclr,
    input  logic apre,
    input  logic ce,
    input  logic d,
    output logic q
);
    logic clr;
    logic q_d, q_q;

    assign clr = aclr | ~rst_n;

    always_comb begin
        q_d = ce ? d : q_q;
    end

    always_ff @(posedge clk or posedge clr or posedge apre) begin
        if (clr) begin
            q_q <= 1'b0;
        end else if (apre) begin
            q_q <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        aclr |-> !q_q); // R11
    AST_PRESET_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (apre && !aclr) |-> q_q); // R11
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !aclr && !apre) |=> (aclr || apre || $stable(q_q))); // R6
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [LUT_K-1:0] din,
    input  logic             cin,
    input  logic             casc_in,
    input  logic             ce,
    input  logic             aclr,
    input  logic             apre,
    output logic             loc_out,
    output logic             glb_out,
    output logic             cout,
    output logic             casc_out
);
    cell_cfg_t cfg_q;
    eval_t     ev;
    logic      reg_q;

    lut_cell_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg_q)
    );

    lut_cell_eval u_eval (
        .cfg     (cfg_q),
        .din     (din),
        .cin     (cin),
        .casc_in (casc_in),
        .q       (reg_q),
        .ev      (ev)
    );

    lut_cell_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .aclr  (aclr),
        .apre  (apre),
        .ce    (ce),
        .d     (ev.reg_d),
        .q     (reg_q)
    );

    always_comb begin
        loc_out  = cfg_q.loc_sel ? reg_q : ev.comb;
        glb_out  = cfg_q.glb_sel ? reg_q : ev.comb;
        cout     = ev.cout;
        casc_out = ev.comb;
    end

    AST_CASC_AND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.casc_or && !casc_in) |-> !casc_out); // R4
    AST_CASC_OR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.casc_or && casc_in) |-> casc_out); // R4
    AST_OUT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.loc_sel == cfg_q.glb_sel) |-> (loc_out == glb_out)); // R5
    AST_NO_CARRY_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.mode == MODE_NORMAL) || (cfg_q.mode == MODE_SPARE)) |-> !cout); // R8
    AST_PACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.mode != MODE_COUNT) && cfg_q.reg_pack && ce && !aclr && !apre)
        |=> (aclr || apre || (reg_q == $past(din[3])))); // R7
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.mode == MODE_COUNT) && din[2] && ce && !aclr && !apre)
        |=> (aclr || apre || (reg_q == $past(din[0])))); // R10
endmodule

// File: tb/tb_lut_cell.sv
`timescale 1ns/1ps
module tb_lut_cell;
    localparam int N = 4;

    typedef struct packed {
        logic [3:0] a;
        logic [3:0] b;
        logic       ci;
    } add_vec_t;

    localparam add_vec_t ADD_VECS [7] = '{
        '{4'd3,  4'd4,  1'b0},
        '{4'd15, 4'd1,  1'b0},
        '{4'd15, 4'd15, 1'b1},
        '{4'd0,  4'd0,  1'b1},
        '{4'd9,  4'd6,  1'b0},
        '{4'd10, 4'd5,  1'b1},
        '{4'd8,  4'd8,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [22:0] cfg_wdata = '0;
    logic [3:0]  din_tb [N];
    logic        cin0 = 1'b0;
    logic [N-1:0] casc_tb = '1;
    logic        link = 1'b0;
    logic        ce = 1'b1;
    logic        aclr = 1'b0;
    logic        apre = 1'b0;

    logic [N-1:0] cin_w, casc_in_w, loc_w, glb_w, cout_w, casc_out_w;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign cin_w[i]     = cin0;
            assign casc_in_w[i] = casc_tb[i];
        end else begin : g_link
            assign cin_w[i]     = cout_w[i-1];
            assign casc_in_w[i] = link ? casc_out_w[i-1] : casc_tb[i];
        end
        lut_cell dut (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we),
            .cfg_wdata (cfg_wdata),
            .din       (din_tb[i]),
            .cin       (cin_w[i]),
            .casc_in   (casc_in_w[i]),
            .ce        (ce),
            .aclr      (aclr),
            .apre      (apre),
            .loc_out   (loc_w[i]),
            .glb_out   (glb_w[i]),
            .cout      (cout_w[i]),
            .casc_out  (casc_out_w[i])
        );
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [22:0] mk(logic [15:0] m, logic [1:0] md, logic cs,
                                       logic co, logic pk, logic ls, logic gs);
        return {gs, ls, pk, co, cs, md, m};
    endfunction

    task automatic load_cfg(input logic [22:0] w);
        cfg_wdata = w;
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic set_all(input logic [3:0] v);
        for (int i = 0; i < N; i++) din_tb[i] = v;
    endtask

    task automatic set_count(input logic en, input logic ld, input logic up, input logic [3:0] val);
        for (int i = 0; i < N; i++) din_tb[i] = {en, ld, up, val[i]};
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] m;
        logic [4:0]  sum_exp;
        logic [3:0]  cnt;
        set_all(4'h0);
        step();
        step();
        // R1: reset state, zero config gives zero outputs
        chk("R1 reset loc", loc_w[0], 0);
        chk("R1 reset glb", glb_w[0], 0);
        chk("R1 reset cout", cout_w[0], 0);
        rst_n = 1'b1;
        step();
        chk("R1 after reset casc", casc_out_w[0], 0);

        // R2 R6: general-logic table walk, then registered copy
        m = 16'hA5C3;
        load_cfg(mk(m, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        for (int v = 0; v < 16; v++) begin
            din_tb[0] = v[3:0];
            #1;
            chk("R2 table", loc_w[0], m[v]);
            chk("R8 no carry in general", cout_w[0], 0);
            step();
            chk("R6 register loads comb", glb_w[0], m[v]);
        end

        // R3: carry-in replaces din[2]
        load_cfg(mk(16'hF0F0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        din_tb[0] = 4'b0000; cin0 = 1'b1; #1;
        chk("R3 cin selects high", loc_w[0], 1);
        din_tb[0] = 4'b0100; cin0 = 1'b0; #1;
        chk("R3 din2 ignored", loc_w[0], 0);
        step();
        // R2: mode 3 acts as general logic
        load_cfg(mk(16'h0002, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        din_tb[0] = 4'b0001; #1;
        chk("R2 spare mode", loc_w[0], 1);
        chk("R8 spare mode no carry", cout_w[0], 0);

        // R4: cascade AND and OR
        load_cfg(mk(16'hFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        casc_tb[0] = 1'b0; #1;
        chk("R4 AND blocks", casc_out_w[0], 0);
        casc_tb[0] = 1'b1; #1;
        chk("R4 AND passes", loc_w[0], 1);
        step();
        load_cfg(mk(16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        #1;
        chk("R4 OR forces", casc_out_w[0], 1);
        casc_tb[0] = 1'b0; #1;
        chk("R4 OR passes zero", loc_w[0], 0);
        casc_tb[0] = 1'b1;
        step();

        // R7 R5: packing, table on local, register on global
        load_cfg(mk(16'h8080, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
        din_tb[0] = 4'b1000;
        step();
        chk("R7 packed reg takes din3", glb_w[0], 1);
        chk("R5 local shows table", loc_w[0], 0);
        din_tb[0] = 4'b0111;
        step();
        chk("R7 packed reg cleared", glb_w[0], 0);
        chk("R5 local table one", loc_w[0], 1);
        ce = 1'b0;
        din_tb[0] = 4'b1000;
        step();
        chk("R6 ce low holds", glb_w[0], 0);

        // R11: async preset/clear between edges
        apre = 1'b1; #1;
        chk("R11 preset without clock", glb_w[0], 1);
        step();
        aclr = 1'b1; #1;
        chk("R11 clear wins", glb_w[0], 0);
        step();
        apre = 1'b0;
        step();
        aclr = 1'b0;
        step();
        chk("R11 stays clear", glb_w[0], 0);
        ce = 1'b1;

        // R8 R12: ripple adder from vector table
        load_cfg(mk(16'hE896, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        foreach (ADD_VECS[k]) begin
            for (int i = 0; i < N; i++) din_tb[i] = {2'b00, ADD_VECS[k].b[i], ADD_VECS[k].a[i]};
            cin0 = ADD_VECS[k].ci;
            #1;
            sum_exp = 5'(ADD_VECS[k].a) + 5'(ADD_VECS[k].b) + 5'(ADD_VECS[k].ci);
            chk("R12 R8 adder chain", {cout_w[3], loc_w}, sum_exp);
            step();
        end
        // R4: cascade still active in arithmetic mode
        set_all(4'h0);
        din_tb[0] = 4'b0001; cin0 = 1'b0; casc_tb[0] = 1'b0; #1;
        chk("R4 arith cascade blocks sum", loc_w[0], 0);
        casc_tb[0] = 1'b1; #1;
        chk("R8 arith sum", loc_w[0], 1);
        step();

        // R12: 16-input AND through cascade links
        load_cfg(mk(16'h8000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        link = 1'b1;
        set_all(4'hF); #1;
        chk("R12 wide AND true", casc_out_w[3], 1);
        din_tb[2] = 4'b1110; #1;
        chk("R12 wide AND false", casc_out_w[3], 0);
        link = 1'b0;
        step();

        // R9 R10: 4-bit up/down counter chain
        load_cfg(mk(16'h905A, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cin0 = 1'b1;
        cnt = 4'd14;
        set_count(1'b0, 1'b1, 1'b1, cnt);
        step();
        chk("R10 load", glb_w, cnt);
        set_count(1'b1, 1'b0, 1'b1, 4'd0);
        for (int s = 0; s < 3; s++) begin
            step();
            cnt = cnt + 4'd1;
            chk("R9 count up", glb_w, cnt);
        end
        set_count(1'b0, 1'b0, 1'b1, 4'd0);
        step();
        chk("R9 enable low holds", glb_w, cnt);
        set_count(1'b1, 1'b0, 1'b0, 4'd0);
        for (int s = 0; s < 3; s++) begin
            step();
            cnt = cnt - 4'd1;
            chk("R9 count down", glb_w, cnt);
        end
        ce = 1'b0;
        step();
        chk("R6 counter ce low holds", glb_w, cnt);
        ce = 1'b1;
        set_count(1'b1, 1'b1, 1'b1, 4'd5);
        step();
        chk("R10 load beats enable", glb_w, 4'd5);

        finish_run();
    end
endmodule